// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register for parallel-to-serial conversion. A byte presented on the parallel inputs is captured while the active-low load control is held low. The load is level-sensitive and takes priority over all clocking. With the load control high, the stages move one place toward the last stage on each rising edge of a gated shift clock. The first stage takes the serial input. The last stage drives the serial output and an inverted copy of it.

The shift clock and its hold input play interchangeable roles. They are combined by OR into one gated clock, so a rising edge on either input causes a shift while the other input is low. Taking the hold input high while the shift clock is already high enters the held state without a shift.

The external shift clock, hold, load and serial pins are asynchronous to the block. They are sampled by a free-running system clock through a two-flop synchronizer. Shifts are then triggered by rising edges of the sampled gated clock. The parallel inputs are not synchronized; they are expected to be stable while the load control is low or is being released.

Top module: `piso_shreg`

## Requirements
- R1: A synchronous active-low reset clears every stage to zero, so `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is low, `stage_q[i]` follows `par_in[i]` on every system clock. This holds whatever the levels of `shift_clk`, `shift_hold` and `ser_in`. Bit 0 is the first stage and bit 7 is the last stage.
- R3: While `load_n` is high, changes on `par_in` leave the stages unchanged.
- R4: A rising edge on `shift_clk` while `shift_hold` is low and `load_n` is high causes exactly one shift: `stage_q` becomes `{stage_q[6:0], ser_in}`. A falling edge causes no shift.
- R5: A rising edge on `shift_hold` while `shift_clk` is low and `load_n` is high causes exactly one shift of the same form as in R4.
- R6: While either gate input is held high, toggling the other input causes no shift.
- R7: Raising `shift_hold` while `shift_clk` is high causes no shift.
- R8: `ser_out` always equals `stage_q[7]`, and `ser_out_n` is always its inverse, with no extra latency.
- R9: With the default two synchronizer stages, a pin change made between system clock edges takes effect on `stage_q` at the third rising system clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Asynchronous shift clock pin |
| shift_hold | input | 1 | Asynchronous hold pin; interchangeable with `shift_clk` |
| load_n | input | 1 | Asynchronous active-low parallel load control |
| ser_in | input | 1 | Serial data for the first stage |
| par_in | input | 8 | Parallel data; bit 0 goes to the first stage |
| stage_q | output | 8 | Contents of all stages; bit 7 is the last stage |
| ser_out | output | 1 | Last stage value |
| ser_out_n | output | 1 | Inverse of `ser_out` |

## Verification
A wrong stage value shows on `stage_q` three system clocks after the pin change that caused it. It reaches `ser_out` after at most seven further shifts. A spurious or missed shift moves every bit by one position. It therefore shows at once on the stage view and at the next serial bit. A load path that leaks while `load_n` is high shows within three cycles of a change on `par_in`. The bench keeps its own model of the stages. It compares that model with all outputs after every pin step, so an edge-detector fault that mis-times a shift also shows as a one-step offset.

// File: rtl/piso_pkg.sv
// Shared types for the parallel-load serial-out shift register.
// Assumes: the asynchronous control pins travel together through one synchronizer.
package piso_pkg;

    // Default number of stages in the register.
    localparam int unsigned STAGES_DEF = 8;

    // Default synchronizer depth for the asynchronous pins.
    localparam int unsigned SYNC_DEF = 2;

    // Bundle of asynchronous pins that share one synchronizer.
    typedef struct packed {
        logic clk_a;   // shift clock pin
        logic clk_b;   // hold pin, same role as clk_a
        logic load_n;  // active-low load control
        logic ser;     // serial data for the first stage
    } pin_bundle_t;

    localparam int unsigned PIN_BITS = $bits(pin_bundle_t);

    // Reset value of the synchronizer: load inactive, clocks low, serial low.
    localparam pin_bundle_t PIN_RST = '{clk_a: 1'b0, clk_b: 1'b0, load_n: 1'b1, ser: 1'b0};

endpackage

// File: rtl/pin_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous pins.
// Assumes: the bits of the bundle are independent single-bit signals; each bit
// is made metastability-safe on its own, so no multi-bit coherence is implied.
module pin_sync #(
    parameter int unsigned            N       = 4,
    parameter int unsigned            STAGES  = 2,
    parameter logic [N-1:0]           RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][N-1:0] chain;

    // Move the samples one flop further along the chain each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/gate_edge.sv
// Combines two interchangeable clock pins by OR into one gated clock and
// flags each rising edge of it as a single-cycle pulse.
// Assumes: both inputs are already synchronous to clk.
module gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_a,
    input  logic clk_b,
    output logic rise
);

    logic gated;
    logic gated_prev;

    // Gated clock: either pin high holds the gate high.
    always_comb begin
        gated = clk_a | clk_b;
    end

    // Remember the previous gated level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_prev <= 1'b0;
        end else begin
            gated_prev <= gated;
        end
    end

    // Rising edge: gate high now and low one cycle ago.
    always_comb begin
        rise = gated & ~gated_prev;
    end

endmodule

// File: rtl/stage_chain.sv
// The storage stages, with a level-sensitive parallel load that takes
// priority over a one-place shift toward the last stage.
// Assumes: load and shift are synchronous; par is stable while load is high.
module stage_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             ser,
    input  logic [WIDTH-1:0] par,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] shifted;

    // Per-stage shift source: the serial input for stage 0, the stage before for the rest.
    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        if (i == 0) begin : g_first
            assign shifted[i] = ser;
        end else begin : g_next
            assign shifted[i] = q[i-1];
        end
    end

    // Update the stages: reset, then load, then shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= par;
        end else if (shift) begin
            q <= shifted;
        end
    end

endmodule

// File: rtl/piso_shreg.sv
// Parallel-load serial-out shift register sampled by a system clock.
// The asynchronous shift clock, hold, load and serial pins are synchronized,
// the two clock pins are ORed into a gated clock whose rising edges shift the
// stages, and a low load control copies the parallel inputs every cycle.
// Assumes: par_in is stable while load_n is low or being released; all four
// asynchronous pins are low (load_n high) during reset.
module piso_shreg
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH       = STAGES_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             shift_clk,
    input  logic             shift_hold,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q,
    output logic             ser_out,
    output logic             ser_out_n
);

    localparam int unsigned TOP = WIDTH - 1;

    pin_bundle_t pins_raw;
    pin_bundle_t pins_s;
    logic [PIN_BITS-1:0] pins_q;

    logic clk_s;
    logic hold_s;
    logic load_n_s;
    logic ser_s;
    logic shift_pulse;

    // Gather the asynchronous pins into one bundle.
    always_comb begin
        pins_raw.clk_a  = shift_clk;
        pins_raw.clk_b  = shift_hold;
        pins_raw.load_n = load_n;
        pins_raw.ser    = ser_in;
    end

    pin_sync #(
        .N       (PIN_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (pins_raw),
        .q     (pins_q)
    );

    // Unpack the synchronized bundle into named signals.
    always_comb begin
        pins_s   = pins_bundle(pins_q);
        clk_s    = pins_s.clk_a;
        hold_s   = pins_s.clk_b;
        load_n_s = pins_s.load_n;
        ser_s    = pins_s.ser;
    end

    gate_edge u_edge (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .clk_a (clk_s),
        .clk_b (hold_s),
        .rise  (shift_pulse)
    );

    stage_chain #(
        .WIDTH (WIDTH)
    ) u_chain (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .load  (!load_n_s),
        .shift (shift_pulse),
        .ser   (ser_s),
        .par   (par_in),
        .q     (stage_q)
    );

    // Serial outputs straight from the last stage.
    always_comb begin
        ser_out   = stage_q[TOP];
        ser_out_n = ~stage_q[TOP];
    end

    function automatic pin_bundle_t pins_bundle(input logic [PIN_BITS-1:0] v);
        return pin_bundle_t'(v);
    endfunction

endmodule

// File: rtl/piso_shreg_chk.sv
// Property checker for piso_shreg, attached with bind.
// Assumes: it sees the synchronized pins and the shift pulse of the top.
module piso_shreg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_s,
    input logic         hold_s,
    input logic         load_n_s,
    input logic         ser_s,
    input logic         shift_pulse,
    input logic [W-1:0] par_in,
    input logic [W-1:0] stage_q,
    input logic         ser_out,
    input logic         ser_out_n
);

    logic was_in_reset = 1'b0;

    // Track whether the previous edge saw reset asserted.
    always @(posedge clk) begin
        if (was_in_reset) begin
            a_reset_clear_r1: assert (stage_q == '0)
                else $error("stages not cleared after reset");
        end
        was_in_reset <= !rst_n;
    end

    p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> (stage_q == $past(par_in)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !shift_pulse) |=> $stable(stage_q));

    p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && shift_pulse) |=> (stage_q == {$past(stage_q[W-2:0]), $past(ser_s)}));

    p_hold_blocks_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s && $past(hold_s)) |-> !shift_pulse);

    p_clk_blocks_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_s && $past(clk_s)) |-> !shift_pulse);

    p_last_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == stage_q[W-1]);

    p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_n != ser_out);

endmodule

bind piso_shreg piso_shreg_chk #(.W(WIDTH)) u_chk (
    .clk         (sys_clk),
    .rst_n       (sys_rst_n),
    .clk_s       (clk_s),
    .hold_s      (hold_s),
    .load_n_s    (load_n_s),
    .ser_s       (ser_s),
    .shift_pulse (shift_pulse),
    .par_in      (par_in),
    .stage_q     (stage_q),
    .ser_out     (ser_out),
    .ser_out_n   (ser_out_n)
);

// File: tb/piso_shreg_test.sv
`timescale 1ns/1ps
module piso_shreg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       p_clk = 1'b0;
    logic       p_hold = 1'b0;
    logic       p_load_n = 1'b1;
    logic       p_ser = 1'b0;
    logic [7:0] p_par = 8'h00;
    logic [7:0] stage_q;
    logic       ser_out;
    logic       ser_out_n;

    int   checks = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q = 8'h00;

    always #2 clk = ~clk;

    piso_shreg uut (
        .sys_clk    (clk),
        .sys_rst_n  (rst_n),
        .shift_clk  (p_clk),
        .shift_hold (p_hold),
        .load_n     (p_load_n),
        .ser_in     (p_ser),
        .par_in     (p_par),
        .stage_q    (stage_q),
        .ser_out    (ser_out),
        .ser_out_n  (ser_out_n)
    );

    function automatic logic [7:0] f_shift(input logic [7:0] q, input logic s);
        return {q[6:0], s};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    // Compare all outputs against the model (R8 on the serial pair).
    task automatic check_all(input string tag);
        check(tag, stage_q, exp_q);
        check({tag, " R8 ser_out"}, {7'd0, ser_out}, {7'd0, exp_q[7]});
        check({tag, " R8 ser_out_n"}, {7'd0, ser_out_n}, {7'd0, ~exp_q[7]});
    endtask

    // Drive one pin step, update the model, wait past the latency and check.
    task automatic apply(input logic c, input logic h, input logic ld,
                         input logic s, input logic [7:0] par, input string tag);
        logic old_g;
        logic new_g;
        logic [7:0] p;
        p = par;
        if (ld && !p_load_n) p = p_par;  // par stable while load is released
        old_g = p_clk | p_hold;
        new_g = c | h;
        @(negedge clk);
        p_clk = c; p_hold = h; p_load_n = ld; p_ser = s; p_par = p;
        if (!ld) exp_q = p;
        else if (!old_g && new_g) exp_q = f_shift(exp_q, s);
        repeat (4) @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");

        // R2: load wins over clock, hold and serial activity.
        apply(0, 0, 0, 0, 8'hA5, "R2 load");
        apply(1, 0, 0, 1, 8'hA5, "R2 clk edge during load");
        apply(0, 1, 0, 0, 8'hA5, "R2 hold edge during load");
        apply(0, 0, 0, 1, 8'hA5, "R2 serial toggle during load");
        apply(0, 0, 1, 0, 8'h00, "R2 release load");

        // R3: parallel changes while load is high are ignored.
        apply(0, 0, 1, 0, 8'h3C, "R3 par ignored");

        // R4: walk a serial pattern through all eight stages.
        for (int i = 0; i < 8; i++) begin
            apply(1, 0, 1, (8'b1011_0010 >> i) & 1'b1, 8'h3C, "R4 clk rise");
            apply(0, 0, 1, 1'b0, 8'h3C, "R4 clk fall no shift");
        end

        // R5: hold rising with clock low shifts.
        apply(0, 1, 1, 1, 8'h3C, "R5 hold rise");
        apply(0, 0, 1, 0, 8'h3C, "R5 hold fall");

        // R7 then R6: enter inhibit safely, then toggle the clock.
        apply(1, 0, 1, 1, 8'h3C, "R4 clk rise");
        apply(1, 1, 1, 0, 8'h3C, "R7 hold rise with clk high");
        apply(0, 1, 1, 1, 8'h3C, "R6 clk fall while held");
        apply(1, 1, 1, 0, 8'h3C, "R6 clk rise while held");
        apply(0, 1, 1, 1, 8'h3C, "R6 clk fall while held");
        apply(0, 0, 1, 0, 8'h3C, "R6 release hold");

        // R9: latency of exactly three system clock edges.
        @(negedge clk);
        p_clk = 1'b1; p_ser = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 no change after two edges", stage_q, exp_q);
        exp_q = f_shift(exp_q, 1'b1);
        @(negedge clk);
        check("R9 change at third edge", stage_q, exp_q);
        apply(0, 0, 1, 0, 8'h3C, "R9 settle");

        // Constrained random mix of pin steps.
        for (int n = 0; n < 300; n++) begin
            int unsigned kind;
            logic [7:0] rp;
            logic rs;
            kind = $urandom_range(0, 5);
            rp = 8'($urandom);
            rs = 1'($urandom);
            case (kind)
                0: begin
                    apply(0, 0, 0, rs, rp, "R2 random load");
                    apply(0, 0, 1, rs, rp, "R2 random release");
                end
                1: begin
                    apply(1, 0, 1, rs, p_par, "R4 random clk rise");
                    apply(0, 0, 1, rs, p_par, "R4 random clk fall");
                end
                2: begin
                    apply(0, 1, 1, rs, p_par, "R5 random hold rise");
                    apply(0, 0, 1, rs, p_par, "R5 random hold fall");
                end
                3: begin
                    apply(1, 0, 1, rs, p_par, "R4 random clk rise");
                    apply(1, 1, 1, ~rs, p_par, "R7 random hold with clk high");
                    apply(0, 1, 1, rs, p_par, "R6 random clk fall held");
                    apply(1, 1, 1, ~rs, p_par, "R6 random clk rise held");
                    apply(0, 1, 1, rs, p_par, "R6 random clk fall held");
                    apply(0, 0, 1, rs, p_par, "R6 random release");
                end
                4: begin
                    apply(0, 1, 1, rs, p_par, "R5 random hold rise");
                    apply(1, 1, 1, ~rs, p_par, "R6 random clk rise while hold high");
                    apply(1, 0, 1, rs, p_par, "R6 random hold fall while clk high");
                    apply(0, 0, 1, rs, p_par, "R6 random clk fall");
                end
                default: apply(0, 0, 1, rs, rp, "R3 random par change");
            endcase
        end

        // R1: reset in the middle of activity clears the stages.
        apply(0, 0, 0, 0, 8'hFF, "R2 load before reset");
        apply(0, 0, 1, 0, 8'hFF, "R2 release before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_q = 8'h00;
        check_all("R1 reset clears");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 after reset release");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule